// File: doc/BRIEF.md
# Bus fault status capture unit

This unit sits beside the bus controller of a pipelined processor and keeps a record of the bus cycle that faulted. When a fault is signalled it latches the transfer direction, the operand size still left to move, the three function-code bits and a fault class. It presents them as a 16-bit status word ready for the exception stack frame. When the frame is popped on return from exception, the restored word goes back through the unit. Its direction, size and function-code fields are handed to the bus controller only when the word's rerun bit is set.

Writes that complete after the next instruction has started are called released writes, and they need their own handling. A fault on such a write does not raise an exception at once. The unit keeps it pending and raises it at the next instruction boundary. If a later instruction asks for an operand access before that boundary, the unit aborts that access at once and acknowledges the pending fault, so the instruction never works on stale memory. While a fault is pending, any further fault is dropped, so the captured status stays the one that belongs to the pending fault.

Top module: `bus_fault_capture`

## Requirements
- R1: Bit 6 of `stack_word` holds the captured direction: 1 for a prefetch or operand read (`cyc_rd`=1), 0 for an operand write.
- R2: Bits 5:4 of `stack_word` hold the remaining size: 00 long word, 01 byte, 10 word. An original byte reports 01. An original word reports 10. An original long word reports 00 if `cyc_word_done`=0 and 10 (word) if its first word already moved (`cyc_word_done`=1).
- R3: Bits 2:0 of `stack_word` are a copy of `cyc_fc` for the faulted cycle.
- R4: An accepted fault sets bit 12 (rerun) of `stack_word` to 1, and all captured outputs update in the cycle after the fault strobe.
- R5: A cycle with `unstack_valid`=1 and `unstack_word[12]`=1 gives `reload_valid`=1 in the next cycle, with `reload_rw`=word[6], `reload_size`=word[5:4] and `reload_fc`=word[2:0]. If bit 12 is 0, `reload_valid` stays 0.
- R6: Bits 15:13, 11:7 and 3 of `stack_word` are always 0, and those bits of `unstack_word` have no effect on the reloaded fields.
- R7: A fault on a write with `cyc_released`=1 sets `wr_pending` in the next cycle without raising `exc_req`. At the next `boundary_strb`, `exc_req` pulses for one cycle and `wr_pending` clears.
- R8: `opacc_abort` equals 1 in the same cycle as `opacc_req` while `wr_pending`=1, and is 0 otherwise. The request acknowledges the fault: in the next cycle `exc_req`=1 and `wr_pending`=0.
- R9: A fault that is not a released write raises `exc_req` for one cycle after the strobe and leaves `wr_pending` at 0.
- R10: `fault_type` encodes 01 released write, 10 during exception processing (`cyc_in_exc`), 11 during multi-register move (`cyc_movem`), 00 any other cycle, with priority in that order. A read never counts as a released write.
- R11: A fault strobe while `wr_pending`=1 changes neither the captured status nor `fault_type`, and raises no `exc_req`.
- R12: After reset, `stack_word`, `fault_type`, `wr_pending`, `exc_req` and `reload_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_rd | input | 1 | Current cycle is a read or prefetch |
| cyc_orig_size | input | 2 | Original operand size (00 long, 01 byte, 10 word) |
| cyc_word_done | input | 1 | First word of a long operand already transferred |
| cyc_fc | input | 3 | Function code of the current cycle |
| cyc_released | input | 1 | Current write is a released write |
| cyc_in_exc | input | 1 | Cycle belongs to exception processing |
| cyc_movem | input | 1 | Cycle belongs to a multi-register move |
| fault_strb | input | 1 | Fault reported on the current cycle |
| boundary_strb | input | 1 | Instruction boundary reached |
| opacc_req | input | 1 | Instruction requests an operand access |
| unstack_valid | input | 1 | Restored status word is present |
| unstack_word | input | 16 | Restored status word |
| stack_word | output | 16 | Packed status word for stacking |
| fault_type | output | 2 | Captured fault class |
| wr_pending | output | 1 | Released-write fault awaiting report |
| exc_req | output | 1 | One-cycle exception request |
| opacc_abort | output | 1 | Abort the requested operand access |
| reload_valid | output | 1 | Reload fields valid for the bus controller |
| reload_rw | output | 1 | Reloaded direction |
| reload_size | output | 2 | Reloaded remaining size |
| reload_fc | output | 3 | Reloaded function code |

## Verification
The embedded properties assume the fault and boundary strobes refer to the cycle descriptor presented in the same clock. They also assume a restored word is seen only as a single-cycle `unstack_valid` pulse. The stimulus changes every input only on the falling edge and holds the descriptor steady around each strobe. It keeps the reserved size code 11 out of the fault vectors and resolves each pending fault, through a boundary or an operand request, before the next table entry. The directed tests break that discipline on purpose in one place only: a second fault arrives while one is pending. This is the case the hold rule covers.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

  localparam int SW_W    = 16;
  localparam int FC_W    = 3;
  localparam int SZ_W    = 2;
  localparam int RR_BIT  = 12;
  localparam int RW_BIT  = 6;
  localparam int SZ_LSB  = 4;
  localparam int FC_LSB  = 0;

  localparam logic [SZ_W-1:0] SZ_LONG = 2'b00;
  localparam logic [SZ_W-1:0] SZ_BYTE = 2'b01;
  localparam logic [SZ_W-1:0] SZ_WORD = 2'b10;

  typedef enum logic [1:0] {
    FT_OTHER    = 2'b00,
    FT_RELEASED = 2'b01,
    FT_EXCPROC  = 2'b10,
    FT_MULTIREG = 2'b11
  } fault_kind_t;

  typedef struct packed {
    logic            rr;
    logic            rw;
    logic [SZ_W-1:0] sz;
    logic [FC_W-1:0] fc;
  } fault_rec_t;

  function automatic logic [SZ_W-1:0] remaining_size(
    input logic [SZ_W-1:0] orig, input logic first_word_done);
    logic [SZ_W-1:0] r;
    case (orig)
      SZ_LONG: r = first_word_done ? SZ_WORD : SZ_LONG;
      SZ_BYTE: r = SZ_BYTE;
      SZ_WORD: r = SZ_WORD;
      default: r = orig;
    endcase
    return r;
  endfunction

  function automatic fault_kind_t classify(
    input logic released_wr, input logic in_exc, input logic movem);
    if (released_wr)  return FT_RELEASED;
    else if (in_exc)  return FT_EXCPROC;
    else if (movem)   return FT_MULTIREG;
    else              return FT_OTHER;
  endfunction

  function automatic logic [SW_W-1:0] pack_word(input fault_rec_t f);
    logic [SW_W-1:0] w;
    w = '0;
    w[RR_BIT] = f.rr;
    w[RW_BIT] = f.rw;
    w[SZ_LSB +: SZ_W] = f.sz;
    w[FC_LSB +: FC_W] = f.fc;
    return w;
  endfunction

  function automatic fault_rec_t unpack_word(input logic [SW_W-1:0] w);
    fault_rec_t f;
    f.rr = w[RR_BIT];
    f.rw = w[RW_BIT];
    f.sz = w[SZ_LSB +: SZ_W];
    f.fc = w[FC_LSB +: FC_W];
    return f;
  endfunction

endpackage

// File: rtl/bfc_size_calc.sv
module bfc_size_calc
  import bfc_pkg::*;
(
  input  logic [SZ_W-1:0] orig_size,
  input  logic            word_done,
  output logic [SZ_W-1:0] rem_size
);

  always_comb rem_size = remaining_size(orig_size, word_done);

  // R2: a byte never reports anything but byte
  always_comb begin
    if (orig_size == SZ_BYTE)
      a_r2_byte_kept: assert (rem_size == SZ_BYTE);
  end

endmodule

// File: rtl/bfc_capture.sv
module bfc_capture
  import bfc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_rd,
  input  logic [SZ_W-1:0] rem_size,
  input  logic [FC_W-1:0] cyc_fc,
  input  logic            cyc_released,
  input  logic            cyc_in_exc,
  input  logic            cyc_movem,
  input  logic            fault_strb,
  input  logic            boundary_strb,
  input  logic            opacc_req,
  output fault_rec_t      rec,
  output fault_kind_t     kind,
  output logic            wr_pending,
  output logic            exc_req,
  output logic            opacc_abort
);

  logic accept_w;
  logic rel_w;
  logic take_w;

  assign accept_w    = fault_strb & ~wr_pending;
  assign rel_w       = accept_w & cyc_released & ~cyc_rd;
  assign take_w      = wr_pending & (boundary_strb | opacc_req);
  assign opacc_abort = wr_pending & opacc_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec        <= '0;
      kind       <= FT_OTHER;
      wr_pending <= 1'b0;
      exc_req    <= 1'b0;
    end else begin
      if (accept_w) begin
        rec.rr <= 1'b1;
        rec.rw <= cyc_rd;
        rec.sz <= rem_size;
        rec.fc <= cyc_fc;
        kind   <= classify(cyc_released & ~cyc_rd, cyc_in_exc, cyc_movem);
      end
      if (rel_w)       wr_pending <= 1'b1;
      else if (take_w) wr_pending <= 1'b0;
      exc_req <= (accept_w & ~rel_w) | take_w;
    end
  end

  // R7: pending only ever starts from a released write fault
  a_r7_pending_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_pending) |-> $past(fault_strb && cyc_released && !cyc_rd));

  // R7: pending fault reported at boundary
  a_r7_boundary_report: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pending && boundary_strb) |=> (exc_req && !wr_pending));

  // R8: abort acknowledges the pending fault
  a_r8_abort_ack: assert property (@(posedge clk) disable iff (!rst_n)
    opacc_abort |=> (exc_req && !wr_pending));

  // R9: ordinary read fault reports at once
  a_r9_direct_report: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_strb && !wr_pending && cyc_rd) |=> (exc_req && !wr_pending));

  // R11: captured status is frozen while a fault waits
  a_r11_hold_status: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pending |=> ($stable(rec) && $stable(kind)));

endmodule

// File: rtl/bfc_restore.sv
module bfc_restore
  import bfc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            unstack_valid,
  input  logic [SW_W-1:0] unstack_word,
  output logic            reload_valid,
  output logic            reload_rw,
  output logic [SZ_W-1:0] reload_size,
  output logic [FC_W-1:0] reload_fc
);

  fault_rec_t f_w;
  logic       rerun_w;
  logic       unused_bits;

  assign f_w         = unpack_word(unstack_word);
  assign rerun_w     = unstack_valid & f_w.rr;
  assign unused_bits = ^{unstack_word[15:13], unstack_word[11:7], unstack_word[3]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_valid <= 1'b0;
      reload_rw    <= 1'b0;
      reload_size  <= '0;
      reload_fc    <= '0;
    end else begin
      reload_valid <= rerun_w;
      if (rerun_w) begin
        reload_rw   <= f_w.rw;
        reload_size <= f_w.sz;
        reload_fc   <= f_w.fc;
      end
    end
  end

  // R5: reload only follows a restored word with rerun set
  a_r5_rerun_gate: assert property (@(posedge clk) disable iff (!rst_n)
    reload_valid |-> $past(unstack_valid && unstack_word[RR_BIT]));

  // R5: reload fields stay put when no reload occurs
  a_r5_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_valid |-> ($stable(reload_rw) && $stable(reload_size) && $stable(reload_fc)));

endmodule

// File: rtl/bus_fault_capture.sv
module bus_fault_capture
  import bfc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cyc_rd,
  input  logic [1:0]  cyc_orig_size,
  input  logic        cyc_word_done,
  input  logic [2:0]  cyc_fc,
  input  logic        cyc_released,
  input  logic        cyc_in_exc,
  input  logic        cyc_movem,
  input  logic        fault_strb,
  input  logic        boundary_strb,
  input  logic        opacc_req,
  input  logic        unstack_valid,
  input  logic [15:0] unstack_word,
  output logic [15:0] stack_word,
  output logic [1:0]  fault_type,
  output logic        wr_pending,
  output logic        exc_req,
  output logic        opacc_abort,
  output logic        reload_valid,
  output logic        reload_rw,
  output logic [1:0]  reload_size,
  output logic [2:0]  reload_fc
);

  logic [SZ_W-1:0] rem_size_w;
  fault_rec_t      rec_w;
  fault_kind_t     kind_w;

  bfc_size_calc u_size (
    .orig_size (cyc_orig_size),
    .word_done (cyc_word_done),
    .rem_size  (rem_size_w)
  );

  bfc_capture u_cap (
    .clk           (clk),
    .rst_n         (rst_n),
    .cyc_rd        (cyc_rd),
    .rem_size      (rem_size_w),
    .cyc_fc        (cyc_fc),
    .cyc_released  (cyc_released),
    .cyc_in_exc    (cyc_in_exc),
    .cyc_movem     (cyc_movem),
    .fault_strb    (fault_strb),
    .boundary_strb (boundary_strb),
    .opacc_req     (opacc_req),
    .rec           (rec_w),
    .kind          (kind_w),
    .wr_pending    (wr_pending),
    .exc_req       (exc_req),
    .opacc_abort   (opacc_abort)
  );

  bfc_restore u_rst (
    .clk           (clk),
    .rst_n         (rst_n),
    .unstack_valid (unstack_valid),
    .unstack_word  (unstack_word),
    .reload_valid  (reload_valid),
    .reload_rw     (reload_rw),
    .reload_size   (reload_size),
    .reload_fc     (reload_fc)
  );

  assign stack_word = pack_word(rec_w);
  assign fault_type = kind_w;

  // R6: unused stacked bits stay zero
  a_r6_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_word & 16'hEF88) == 16'h0000);

  // R4: a captured fault always carries the rerun bit
  a_r4_rerun_set: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> stack_word[12]);

endmodule

// File: tb/bus_fault_capture_test.sv
module bus_fault_capture_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cyc_rd, cyc_word_done, cyc_released, cyc_in_exc, cyc_movem;
  logic [1:0]  cyc_orig_size;
  logic [2:0]  cyc_fc;
  logic        fault_strb, boundary_strb, opacc_req, unstack_valid;
  logic [15:0] unstack_word;
  logic [15:0] stack_word;
  logic [1:0]  fault_type, reload_size;
  logic        wr_pending, exc_req, opacc_abort, reload_valid, reload_rw;
  logic [2:0]  reload_fc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_fault_capture uut (.*);

  // {rd, orig_size, word_done, fc, released, in_exc, movem, exp_word, exp_type, exp_pend}
  localparam logic [28:0] VEC [0:7] = '{
    {1'b1, 2'b00, 1'b0, 3'd5, 1'b0, 1'b0, 1'b0, 16'h1045, 2'd0, 1'b0},
    {1'b0, 2'b10, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 16'h1021, 2'd0, 1'b0},
    {1'b1, 2'b01, 1'b1, 3'd2, 1'b0, 1'b1, 1'b0, 16'h1052, 2'd2, 1'b0},
    {1'b0, 2'b00, 1'b1, 3'd6, 1'b0, 1'b0, 1'b1, 16'h1026, 2'd3, 1'b0},
    {1'b0, 2'b00, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 16'h1001, 2'd1, 1'b1},
    {1'b0, 2'b01, 1'b1, 3'd5, 1'b1, 1'b1, 1'b0, 16'h1015, 2'd1, 1'b1},
    {1'b1, 2'b10, 1'b0, 3'd7, 1'b1, 1'b0, 1'b1, 16'h1067, 2'd3, 1'b0},
    {1'b1, 2'b00, 1'b1, 3'd3, 1'b0, 1'b1, 1'b1, 16'h1063, 2'd2, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive_cycle(input logic rd, input logic [1:0] osz, input logic wd,
                             input logic [2:0] fc, input logic rel, input logic ex,
                             input logic mv);
    cyc_rd = rd; cyc_orig_size = osz; cyc_word_done = wd; cyc_fc = fc;
    cyc_released = rel; cyc_in_exc = ex; cyc_movem = mv;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive_cycle(0, 2'b00, 0, 3'd0, 0, 0, 0);
    fault_strb = 0; boundary_strb = 0; opacc_req = 0;
    unstack_valid = 0; unstack_word = 16'h0;
    repeat (3) tick();
    rst_n = 1'b1;

    // R12: reset state
    chk("R12 stack_word", {16'h0, stack_word}, 32'h0);
    chk("R12 fault_type", {30'h0, fault_type}, 32'h0);
    chk("R12 wr_pending", {31'h0, wr_pending}, 32'h0);
    chk("R12 exc_req", {31'h0, exc_req}, 32'h0);
    chk("R12 reload_valid", {31'h0, reload_valid}, 32'h0);

    // Table walk: R1 R2 R3 R4 R6 R7 R9 R10
    for (int i = 0; i < 8; i++) begin
      logic [28:0] v;
      v = VEC[i];
      drive_cycle(v[28], v[27:26], v[25], v[24:22], v[21], v[20], v[19]);
      fault_strb = 1;
      tick();
      fault_strb = 0;
      chk("R1 R2 R3 R4 stack_word", {16'h0, stack_word}, {16'h0, v[18:3]});
      chk("R10 fault_type", {30'h0, fault_type}, {30'h0, v[2:1]});
      chk("R7 R9 wr_pending", {31'h0, wr_pending}, {31'h0, v[0]});
      chk("R7 R9 exc_req", {31'h0, exc_req}, {31'h0, ~v[0]});
      if (v[0]) begin
        tick();
        chk("R7 still pending", {31'h0, wr_pending}, 32'h1);
        chk("R7 no early exc", {31'h0, exc_req}, 32'h0);
        boundary_strb = 1;
        tick();
        boundary_strb = 0;
        chk("R7 boundary exc", {31'h0, exc_req}, 32'h1);
        chk("R7 pending cleared", {31'h0, wr_pending}, 32'h0);
      end
      tick();
      chk("R9 exc one cycle", {31'h0, exc_req}, 32'h0);
    end

    // R8: operand access with nothing pending is not aborted
    opacc_req = 1;
    #1;
    chk("R8 no abort idle", {31'h0, opacc_abort}, 32'h0);
    tick();
    opacc_req = 0;
    chk("R8 no exc idle", {31'h0, exc_req}, 32'h0);

    // R8: operand access aborts and acknowledges a pending fault
    drive_cycle(0, 2'b10, 0, 3'd2, 1, 0, 0);
    fault_strb = 1;
    tick();
    fault_strb = 0;
    chk("R8 setup pending", {31'h0, wr_pending}, 32'h1);
    opacc_req = 1;
    #1;
    chk("R8 abort", {31'h0, opacc_abort}, 32'h1);
    tick();
    opacc_req = 0;
    chk("R8 ack exc", {31'h0, exc_req}, 32'h1);
    chk("R8 pending cleared", {31'h0, wr_pending}, 32'h0);
    #1;
    chk("R8 abort drops", {31'h0, opacc_abort}, 32'h0);
    tick();

    // R11: second fault while pending is dropped
    drive_cycle(0, 2'b00, 1, 3'd6, 1, 0, 0);
    fault_strb = 1;
    tick();
    chk("R11 first capture", {16'h0, stack_word}, 32'h1026);
    drive_cycle(1, 2'b01, 0, 3'd3, 0, 1, 0);
    tick();
    fault_strb = 0;
    chk("R11 word held", {16'h0, stack_word}, 32'h1026);
    chk("R11 type held", {30'h0, fault_type}, 32'h1);
    chk("R11 no exc", {31'h0, exc_req}, 32'h0);
    chk("R11 still pending", {31'h0, wr_pending}, 32'h1);
    boundary_strb = 1;
    tick();
    boundary_strb = 0;
    chk("R11 R7 boundary exc", {31'h0, exc_req}, 32'h1);
    tick();

    // R5 R6: reload with rerun set, junk in unused bits
    unstack_word = 16'hB8DE;
    unstack_valid = 1;
    tick();
    unstack_valid = 0;
    chk("R5 reload_valid", {31'h0, reload_valid}, 32'h1);
    chk("R5 R6 reload_rw", {31'h0, reload_rw}, 32'h1);
    chk("R5 R6 reload_size", {30'h0, reload_size}, 32'h1);
    chk("R5 R6 reload_fc", {29'h0, reload_fc}, 32'h6);
    tick();
    chk("R5 reload one cycle", {31'h0, reload_valid}, 32'h0);

    // R5: rerun clear means no reload
    unstack_word = 16'h0067;
    unstack_valid = 1;
    tick();
    unstack_valid = 0;
    chk("R5 no reload", {31'h0, reload_valid}, 32'h0);
    chk("R5 fields kept", {29'h0, reload_fc}, 32'h6);

    // R12: reset clears captured state again
    rst_n = 0;
    tick();
    rst_n = 1;
    chk("R12 reset word", {16'h0, stack_word}, 32'h0);
    chk("R12 reset type", {30'h0, fault_type}, 32'h0);

    done = 1;
    summary();
    $finish;
  end

endmodule